// File: doc/BRIEF.md
# Resolver Angle Counter with Quadrature Emulation

This block holds the absolute shaft angle of a resolver-to-digital tracking loop as a 12-bit count, 4096 steps per turn. The tracking loop and its oscillator are outside the block. They deliver one-cycle step pulses and a direction level. Each pulse moves the count by one position. The direction level chooses between increasing and decreasing angle.

From the same count the block derives the outputs of a 1024-line incremental encoder: two quadrature channels and a zero-position marker. One full cycle of channel A covers four counts, so decoding the edges of both channels by four returns the full 12-bit resolution. The marker is asserted while the count sits at zero. A two-bit select widens the marker to a quarter, a half or a whole A cycle. The raw count is also brought out for other on-chip logic.

All outputs are registers. The encoder outputs and the count load together on the clock edge that takes a step, and they hold their values between steps.

Top module: `angle_quad_emu`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, both quadrature channels to 0 and the marker to 1.
- R2: On a clock edge with the step pulse high and direction high, the count increases by exactly one. With the step pulse low, the count holds.
- R3: On a clock edge with the step pulse high and direction low, the count decreases by exactly one.
- R4: The count wraps modulo 4096. Stepping up from 4095 gives 0, and stepping down from 0 gives 4095.
- R5: Channel A equals bit 1 of the count. Channel B equals bit 1 XOR bit 0 of the count. Counts 0, 1, 2 and 3 therefore give (A,B) = 00, 01, 11, 10.
- R6: With width select 2'b00 (quarter cycle), the marker is 1 only when the count is 0.
- R7: With width select 2'b01 (half cycle), the marker is 1 when the count is 0 or 1.
- R8: With width select 2'b10 or 2'b11 (full cycle), the marker is 1 when the count is 0, 1, 2 or 3.
- R9: The width select is taken only on a step edge. Changing it while no step is taken leaves the marker unchanged until the next step.
- R10: Changing the direction input while no step is taken has no effect on the count or on the encoder outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | One-cycle angle step pulse |
| dir_i | input | 1 | Step direction, 1 = increasing angle |
| nm_sel_i | input | 2 | Marker width: 00 quarter, 01 half, 10/11 full A cycle |
| count_o | output | CNT_W | Registered absolute angle count |
| enc_a_o | output | 1 | Quadrature channel A |
| enc_b_o | output | 1 | Quadrature channel B |
| enc_nm_o | output | 1 | Zero-position marker |

## Verification
The bench drives the count across zero in both directions. A design that wraps wrongly would show a value other than 4095 or 0 at that point, or would stall there. It walks the four quadrature phases forward and backward, which catches channel B taken from the wrong bit or with the wrong sign of lead. It exercises each marker width at the counts just inside and just outside the window, so an off-by-one window shows up as a marker that is one count too wide or too narrow. It also changes the width select and the direction between steps, to expose a design whose outputs follow these inputs without waiting for a step.

// File: rtl/aqe_pkg.sv
package aqe_pkg;
  typedef enum logic [1:0] {
    NM_QUARTER  = 2'b00,
    NM_HALF     = 2'b01,
    NM_FULL     = 2'b10,
    NM_FULL_ALT = 2'b11
  } nm_width_e;
endpackage

// File: rtl/angle_accum.sv
module angle_accum #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             dir,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // natural modulo-2^CNT_W wrap in both directions
  always_comb begin
    if (!step)    count_nxt = count_q;
    else if (dir) count_nxt = count_q + ONE;
    else          count_nxt = count_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nxt;
  end
endmodule

// File: rtl/quad_decode.sv
module quad_decode #(
  parameter int CNT_W      = 12,
  parameter int PHASE_BITS = 2
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             ch_a,
  output logic             ch_b
);
  localparam int HI = PHASE_BITS - 1;
  localparam int LO = PHASE_BITS - 2;

  // Gray sequence within one A cycle: 00, 01, 11, 10
  always_comb begin
    ch_a = cnt[HI];
    ch_b = cnt[HI] ^ cnt[LO];
  end
endmodule

// File: rtl/marker_gen.sv
module marker_gen #(
  parameter int CNT_W      = 12,
  parameter int PHASE_BITS = 2
) (
  input  logic [CNT_W-1:0]      cnt,
  input  aqe_pkg::nm_width_e    width,
  output logic                  hit
);
  logic [CNT_W-1:0] upper;

  // drop the low bits that the chosen width ignores, then test for zero
  always_comb begin
    unique case (width)
      aqe_pkg::NM_QUARTER: upper = cnt;
      aqe_pkg::NM_HALF:    upper = cnt >> (PHASE_BITS - 1);
      default:             upper = cnt >> PHASE_BITS;
    endcase
    hit = (upper == '0);
  end
endmodule

// File: rtl/angle_quad_emu.sv
module angle_quad_emu #(
  parameter int CNT_W      = 12,
  parameter int PHASE_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic [1:0]       nm_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             enc_a_o,
  output logic             enc_b_o,
  output logic             enc_nm_o
);
  logic [CNT_W-1:0]   cnt_nxt;
  logic               a_nxt, b_nxt, nm_nxt;
  aqe_pkg::nm_width_e width;

  assign width = aqe_pkg::nm_width_e'(nm_sel_i);

  angle_accum #(.CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst(rst), .step(step_i), .dir(dir_i),
    .count_q(count_o), .count_nxt(cnt_nxt)
  );

  quad_decode #(.CNT_W(CNT_W), .PHASE_BITS(PHASE_BITS)) u_quad (
    .cnt(cnt_nxt), .ch_a(a_nxt), .ch_b(b_nxt)
  );

  marker_gen #(.CNT_W(CNT_W), .PHASE_BITS(PHASE_BITS)) u_mark (
    .cnt(cnt_nxt), .width(width), .hit(nm_nxt)
  );

  // encoder outputs load with the count, only on a step
  always_ff @(posedge clk) begin
    if (rst) begin
      enc_a_o  <= 1'b0;
      enc_b_o  <= 1'b0;
      enc_nm_o <= 1'b1;
    end else if (step_i) begin
      enc_a_o  <= a_nxt;
      enc_b_o  <= b_nxt;
      enc_nm_o <= nm_nxt;
    end
  end
endmodule

// File: rtl/aqe_checker.sv
module aqe_checker #(
  parameter int CNT_W      = 12,
  parameter int PHASE_BITS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             step_i,
  input logic             dir_i,
  input logic [1:0]       nm_sel_i,
  input logic [CNT_W-1:0] count_o,
  input logic             enc_a_o,
  input logic             enc_b_o,
  input logic             enc_nm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !enc_a_o && !enc_b_o && enc_nm_o));

  assert_up_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i) |=> (count_o - $past(count_o)) == ONE);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(count_o));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !dir_i) |=> ($past(count_o) - count_o) == ONE);

  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i && count_o == TOP) |=> count_o == '0);

  assert_wrap_down_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !dir_i && count_o == '0) |=> count_o == TOP);

  assert_quad_phase_R5: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (enc_a_o == count_o[PHASE_BITS-1]) &&
               (enc_b_o == (count_o[PHASE_BITS-1] ^ count_o[PHASE_BITS-2])));

  assert_marker_quarter_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && nm_sel_i == 2'b00) |=> enc_nm_o == (count_o == '0));

  assert_marker_half_R7: assert property (@(posedge clk) disable iff (rst)
    (step_i && nm_sel_i == 2'b01) |=> enc_nm_o == ((count_o >> 1) == '0));

  assert_marker_full_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && nm_sel_i[1]) |=> enc_nm_o == ((count_o >> PHASE_BITS) == '0));

  assert_quiet_between_steps_R9: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(enc_nm_o) && $stable(enc_a_o) && $stable(enc_b_o)));
endmodule

bind angle_quad_emu aqe_checker #(.CNT_W(CNT_W), .PHASE_BITS(PHASE_BITS)) u_chk (
  .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i), .nm_sel_i(nm_sel_i),
  .count_o(count_o), .enc_a_o(enc_a_o), .enc_b_o(enc_b_o), .enc_nm_o(enc_nm_o)
);

// File: tb/angle_quad_emu_test.sv
module angle_quad_emu_test;
  localparam int CNT_W = 12;
  localparam int NV    = 16;
  // {step, dir, sel[1:0], count[11:0], a, b, nm}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'b01, 12'd1,    1'b0, 1'b1, 1'b1},
    {1'b1, 1'b1, 2'b01, 12'd2,    1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'b10, 12'd3,    1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 2'b10, 12'd4,    1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'b10, 12'd3,    1'b1, 1'b0, 1'b1},
    {1'b1, 1'b0, 2'b00, 12'd2,    1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 2'b00, 12'd1,    1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 2'b00, 12'd0,    1'b0, 1'b0, 1'b1},
    {1'b1, 1'b0, 2'b00, 12'd4095, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'b11, 12'd4094, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 2'b00, 12'd4094, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'b11, 12'd4095, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'b11, 12'd0,    1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 2'b11, 12'd1,    1'b0, 1'b1, 1'b1},
    {1'b1, 1'b1, 2'b00, 12'd2,    1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 2'b01, 12'd2,    1'b1, 1'b1, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             step_i = 1'b0;
  logic             dir_i = 1'b0;
  logic [1:0]       nm_sel_i = 2'b00;
  logic [CNT_W-1:0] count_o;
  logic             enc_a_o, enc_b_o, enc_nm_o;
  int               n_chk = 0;
  int               n_bad = 0;

  always #2 clk = ~clk;

  angle_quad_emu #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i), .nm_sel_i(nm_sel_i),
    .count_o(count_o), .enc_a_o(enc_a_o), .enc_b_o(enc_b_o), .enc_nm_o(enc_nm_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the next rising edge
  task automatic cycle(input logic s, input logic d, input logic [1:0] w);
    @(negedge clk);
    step_i = s; dir_i = d; nm_sel_i = w;
    @(posedge clk);
    #1;
  endtask

  task automatic check_state(input string tag, input int c, input logic a,
                             input logic b, input logic nm);
    check({tag, " count"}, int'(count_o), c);
    check({tag, " A"}, int'(enc_a_o), int'(a));
    check({tag, " B"}, int'(enc_b_o), int'(b));
    check({tag, " marker"}, int'(enc_nm_o), int'(nm));
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_state("R1 reset", 0, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][18], VEC[i][17], VEC[i][16:15]);
      check($sformatf("R2 R3 R4 vec%0d count", i), int'(count_o), int'(VEC[i][14:3]));
      check($sformatf("R5 vec%0d A", i), int'(enc_a_o), int'(VEC[i][2]));
      check($sformatf("R5 vec%0d B", i), int'(enc_b_o), int'(VEC[i][1]));
      check($sformatf("R6 R7 R8 vec%0d marker", i), int'(enc_nm_o), int'(VEC[i][0]));
    end

    // count now 2; full width would mark it, but no step is taken (R9)
    cycle(1'b0, 1'b0, 2'b10);
    cycle(1'b0, 1'b0, 2'b10);
    check_state("R9 width change without step", 2, 1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 2'b10);
    check_state("R9 width taken on step", 1, 1'b0, 1'b1, 1'b1);

    // direction toggles with no step (R10)
    cycle(1'b0, 1'b1, 2'b10);
    cycle(1'b0, 1'b0, 2'b10);
    cycle(1'b0, 1'b1, 2'b10);
    check_state("R10 direction without step", 1, 1'b0, 1'b1, 1'b1);

    // half width boundary: counts 1 in, 2 out (R7)
    cycle(1'b1, 1'b1, 2'b01);
    check_state("R7 half width at 2", 2, 1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 2'b01);
    check_state("R7 half width at 1", 1, 1'b0, 1'b1, 1'b1);

    // full width boundary: 3 in, 4 out (R8)
    cycle(1'b1, 1'b1, 2'b10);
    cycle(1'b1, 1'b1, 2'b10);
    check_state("R8 full width at 3", 3, 1'b1, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 2'b11);
    check_state("R8 full width at 4", 4, 1'b0, 1'b0, 1'b0);

    // reset from a nonzero count (R1)
    cycle(1'b0, 1'b0, 2'b00);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_state("R1 mid-run reset", 0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    finish_run();
  end
endmodule